// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the device-side control logic of a 16-bit parallel NOR flash, reduced to a small register memory. It watches single-cycle write strobes on an address and data bus and recognises unlock-protected command sequences. Completed sequences start a word program, a sector erase, a block erase or a whole-array erase. The time each of these takes is modelled by a cycle counter whose lengths are parameters. While an operation runs, every read returns a status word instead of array data. In that status word one bit is the complement of the bit being written and another bit flips on each read, so a host can poll without a ready pin.

A second command places the device in an identification mode. In that mode two fixed code words replace the array contents at the lowest addresses. An active-low write-protect input shields the bottom block of the array. An active-low reset, sampled on the clock, aborts whatever is in flight. With the default parameters the array holds 64 words. A sector is 4 words, a block is 16 words and the protected boot block is words 0 to 15.

Top module: `nor_flash_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows no operation in progress, read-array mode and `rdata` = 0000h. An operation interrupted this way leaves the array unchanged.
- R2: A word program is the writes AAh@555h, 55h@2AAh and A0h@555h, followed by a fourth write. That fourth write stores its full 16-bit data at word `addr[MEM_AW-1:0]`. During command writes only `wdata[7:0]` and the 15 address bits are compared, and the high data byte is ignored.
- R3: For exactly PROG_CYC, ERASE_CYC or CHIP_CYC cycles after the accepting write, a read returns a status word. In that word bits [15:8] and [5:0] are 0. Bit 7 is the complement of bit 7 of the programmed word, or 0 for any erase. Bit 6 is 0 on the first status read of each operation and inverts on every further status read. The next read returns array data.
- R4: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h set every word to FFFFh.
- R5: The same five-write prefix ended by 50h at any address erases to FFFFh the 2^SECT_W-word sector that contains that address. The sector is selected by `addr[MEM_AW-1:SECT_W]`.
- R6: The prefix ended by 30h erases to FFFFh the 2^BLK_W-word block selected by `addr[MEM_AW-1:BLK_W]`.
- R7: With `wp_n` low, no operation starts for a program, sector erase or block erase aimed at a word with `addr[MEM_AW-1:BLK_W]` = 0. A whole-array erase still runs but leaves that block untouched.
- R8: Every write strobe that arrives while an operation is running is ignored.
- R9: AAh@555h, 55h@2AAh, 90h@555h enter identification mode. In that mode a read at address 0 returns 00BFh, a read at address 1 returns 235Dh and a read at any other address returns 0000h.
- R10: Identification mode is left either by AAh@555h, 55h@2AAh, F0h@555h or by a single write with low data byte F0h to any address. After that, reads return array data again.
- R11: A write that does not match the next expected step of a sequence returns the decoder to idle. A later tail of that sequence then starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| we | input | 1 | Write strobe, one bus write per cycle it is high |
| re | input | 1 | Read strobe; `rdata` is updated at the same edge |
| addr | input | 15 | Word address for reads, writes and command compare |
| wdata | input | 16 | Write data |
| wp_n | input | 1 | Active-low protection of the boot block |
| rdata | output | 16 | Registered read data or status word |

## Verification
The assertions take the following for granted about the inputs:
- `we` and `re` are never high in the same cycle.
- `wp_n` does not change in the middle of a command sequence.
- Every cycle-count parameter is at least one, so the timer can always be loaded.

The stimulus meets these conditions in three ways. Every bus access is a one-cycle task applied at the falling clock edge, each task raises only one strobe, and write-protect is changed only between sequences. The toggle and status-format properties therefore see only status reads that belong to one uninterrupted operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] ADR_FIRST  = 15'h555;
    localparam logic [CMD_AW-1:0] ADR_SECOND = 15'h2AA;

    localparam logic [7:0] KEY_A      = 8'hAA;
    localparam logic [7:0] KEY_B      = 8'h55;
    localparam logic [7:0] CODE_PROG  = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h50;
    localparam logic [7:0] CODE_BLOCK = 8'h30;
    localparam logic [7:0] CODE_IDIN  = 8'h90;
    localparam logic [7:0] CODE_IDOUT = 8'hF0;

    localparam logic [15:0] MAKER_WORD = 16'h00BF;
    localparam logic [15:0] PART_WORD  = 16'h235D;
    localparam logic [15:0] BLANK_WORD = 16'hFFFF;

    typedef enum logic [2:0] {
        DS_IDLE, DS_K1, DS_K2, DS_PROG, DS_E1, DS_E2, DS_E3
    } dec_state_e;

    typedef enum logic [2:0] {
        EV_NONE, EV_PROG, EV_CHIP, EV_SECT, EV_BLOCK, EV_ID_IN, EV_ID_OUT
    } event_e;

    typedef struct packed {
        logic [7:0] hi;
        logic       dq7;
        logic       dq6;
        logic [5:0] lo;
    } status_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic key_hit(input logic [CMD_AW-1:0] a, input logic [15:0] d,
                                     input logic [CMD_AW-1:0] ka, input logic [7:0] kd);
        return (a == ka) && (d[7:0] == kd);
    endfunction

    function automatic logic [15:0] ident_word(input logic [CMD_AW-1:0] a);
        if (a == '0)
            return MAKER_WORD;
        else if (a == CMD_AW'(1))
            return PART_WORD;
        else
            return 16'h0000;
    endfunction

endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CMD_AW-1:0] addr,
    input  logic [15:0]       data,
    output event_e            ev_kind
);

    dec_state_e state, nxt;

    always_comb begin
        nxt     = state;
        ev_kind = EV_NONE;
        if (wr) begin
            nxt = DS_IDLE;
            if (state != DS_PROG && data[7:0] == CODE_IDOUT) begin
                ev_kind = EV_ID_OUT;
            end else begin
                case (state)
                    DS_IDLE: if (key_hit(addr, data, ADR_FIRST, KEY_A)) nxt = DS_K1;
                    DS_K1:   if (key_hit(addr, data, ADR_SECOND, KEY_B)) nxt = DS_K2;
                    DS_K2: begin
                        if (key_hit(addr, data, ADR_FIRST, CODE_PROG))
                            nxt = DS_PROG;
                        else if (key_hit(addr, data, ADR_FIRST, CODE_ERASE))
                            nxt = DS_E1;
                        else if (key_hit(addr, data, ADR_FIRST, CODE_IDIN))
                            ev_kind = EV_ID_IN;
                    end
                    DS_PROG: ev_kind = EV_PROG;
                    DS_E1:   if (key_hit(addr, data, ADR_FIRST, KEY_A)) nxt = DS_E2;
                    DS_E2:   if (key_hit(addr, data, ADR_SECOND, KEY_B)) nxt = DS_E3;
                    DS_E3: begin
                        if (key_hit(addr, data, ADR_FIRST, CODE_CHIP))
                            ev_kind = EV_CHIP;
                        else if (data[7:0] == CODE_SECT)
                            ev_kind = EV_SECT;
                        else if (data[7:0] == CODE_BLOCK)
                            ev_kind = EV_BLOCK;
                    end
                    default: nxt = DS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= DS_IDLE;
        else
            state <= nxt;
    end

    // R11: any decoded event closes the sequence
    p_idle_after_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ev_kind != EV_NONE) |=> (state == DS_IDLE));

endmodule

// File: rtl/op_timer.sv
module op_timer #(
    parameter int CNT_W    = 6,
    parameter int MAX_LOAD = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             running,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign running = (cnt != '0);
    assign done    = (cnt == CNT_W'(1));

    // R8: a new operation is never loaded over a running one
    p_load_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !running);

    // R3: the busy window never exceeds the longest configured length
    p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_LOAD));

endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_cmd_pkg::*;
#(
    parameter int MEM_AW = 6,
    parameter int SECT_W = 2,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              er_en,
    input  event_e            er_kind,
    input  logic [MEM_AW-1:0] er_addr,
    input  logic              keep_boot,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [15:0]       rd_data
);

    localparam int WORDS = 1 << MEM_AW;

    logic [15:0] mem [WORDS];

    function automatic logic erase_hit(input logic [MEM_AW-1:0] idx);
        case (er_kind)
            EV_CHIP:  return !(keep_boot && idx[MEM_AW-1:BLK_W] == '0);
            EV_SECT:  return idx[MEM_AW-1:SECT_W] == er_addr[MEM_AW-1:SECT_W];
            EV_BLOCK: return idx[MEM_AW-1:BLK_W] == er_addr[MEM_AW-1:BLK_W];
            default:  return 1'b0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (er_en && erase_hit(MEM_AW'(i)))
                mem[i] <= BLANK_WORD;
            else if (wr_en && wr_addr == MEM_AW'(i))
                mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int MEM_AW    = 6,
    parameter int SECT_W    = 2,
    parameter int BLK_W     = 4,
    parameter int PROG_CYC  = 7,
    parameter int ERASE_CYC = 20,
    parameter int CHIP_CYC  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [CMD_AW-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              wp_n,
    output logic [15:0]       rdata
);

    localparam int MAX_CYC = max_of(PROG_CYC, max_of(ERASE_CYC, CHIP_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    event_e            ev_kind, pend_kind;
    logic              wr_ok, boot_hit, is_op, blocked, start;
    logic              busy, done, fire, id_mode, tog, keep_boot;
    logic [MEM_AW-1:0] pend_addr;
    logic [15:0]       pend_data, arr_q;
    logic [CNT_W-1:0]  load_val;
    status_t           st;

    assign wr_ok = we && !busy;

    cmd_decoder u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_ok),
        .addr    (addr),
        .data    (wdata),
        .ev_kind (ev_kind)
    );

    always_comb begin
        is_op    = 1'b1;
        load_val = CNT_W'(ERASE_CYC);
        case (ev_kind)
            EV_PROG:  load_val = CNT_W'(PROG_CYC);
            EV_CHIP:  load_val = CNT_W'(CHIP_CYC);
            EV_SECT,
            EV_BLOCK: load_val = CNT_W'(ERASE_CYC);
            default:  is_op = 1'b0;
        endcase
    end

    assign boot_hit = (addr[MEM_AW-1:BLK_W] == '0);
    assign blocked  = !wp_n && boot_hit && (ev_kind != EV_CHIP);
    assign start    = is_op && !id_mode && !blocked;

    op_timer #(
        .CNT_W    (CNT_W),
        .MAX_LOAD (MAX_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (load_val),
        .running  (busy),
        .done     (done)
    );

    assign fire = done && rst_n;

    flash_array #(
        .MEM_AW (MEM_AW),
        .SECT_W (SECT_W),
        .BLK_W  (BLK_W)
    ) u_arr (
        .clk       (clk),
        .wr_en     (fire && pend_kind == EV_PROG),
        .wr_addr   (pend_addr),
        .wr_data   (pend_data),
        .er_en     (fire && pend_kind != EV_PROG),
        .er_kind   (pend_kind),
        .er_addr   (pend_addr),
        .keep_boot (keep_boot),
        .rd_addr   (addr[MEM_AW-1:0]),
        .rd_data   (arr_q)
    );

    always_comb begin
        st.hi  = 8'h00;
        st.dq7 = (pend_kind == EV_PROG) ? ~pend_data[7] : 1'b0;
        st.dq6 = tog;
        st.lo  = 6'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_mode   <= 1'b0;
            tog       <= 1'b0;
            keep_boot <= 1'b0;
            pend_kind <= EV_NONE;
            pend_addr <= '0;
            pend_data <= '0;
            rdata     <= '0;
        end else begin
            if (start) begin
                pend_kind <= ev_kind;
                pend_addr <= addr[MEM_AW-1:0];
                pend_data <= wdata;
                keep_boot <= !wp_n;
                tog       <= 1'b0;
            end
            if (ev_kind == EV_ID_IN)
                id_mode <= 1'b1;
            else if (ev_kind == EV_ID_OUT)
                id_mode <= 1'b0;
            if (re) begin
                if (busy) begin
                    rdata <= st;
                    tog   <= ~tog;
                end else if (id_mode) begin
                    rdata <= ident_word(addr);
                end else begin
                    rdata <= arr_q;
                end
            end
        end
    end

    // R1: reset leaves no operation, no identification mode, cleared read data
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !id_mode && rdata == 16'h0000));

    // R3: unused status bits read as zero
    p_status_zero_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (re && busy) |=> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'h00));

    // R3: consecutive status reads alternate bit 6
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (re && busy && $past(re && busy)) |=> (rdata[6] != $past(rdata[6])));

    // R7: a protected-latched operation never lands inside the boot block
    p_boot_safe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && keep_boot && pend_kind != EV_CHIP) |-> (pend_addr[MEM_AW-1:BLK_W] != '0));

endmodule

// File: tb/sim_nor_flash_ctrl.sv
module sim_nor_flash_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_AW     = 6;
    localparam int SECT_W     = 2;
    localparam int BLK_W      = 4;
    localparam int PROG_CYC   = 7;
    localparam int ERASE_CYC  = 20;
    localparam int CHIP_CYC   = 40;
    localparam int WORDS      = 1 << MEM_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic        wp_n = 1'b1;
    logic [14:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    logic [15:0] exp_mem [WORDS];
    int          n_chk = 0;
    int          n_err = 0;
    logic [7:0]  nz = 8'h00;
    logic [15:0] q;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_flash_ctrl #(
        .MEM_AW (MEM_AW), .SECT_W (SECT_W), .BLK_W (BLK_W),
        .PROG_CYC (PROG_CYC), .ERASE_CYC (ERASE_CYC), .CHIP_CYC (CHIP_CYC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .we (we), .re (re), .addr (addr),
        .wdata (wdata), .wp_n (wp_n), .rdata (rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr(input logic [14:0] a, input logic [15:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, output logic [15:0] r);
        re = 1'b1; addr = a;
        @(negedge clk);
        re = 1'b0;
        r = rdata;
    endtask

    task automatic key(input logic [14:0] a, input logic [7:0] kd);
        wr(a, {nz, kd});
        nz = nz + 8'h3B;
    endtask

    task automatic cmd_prog(input logic [14:0] a, input logic [15:0] d);
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55); key(15'h555, 8'hA0);
        wr(a, d);
    endtask

    task automatic cmd_erase(input logic [14:0] a, input logic [7:0] code);
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55); key(15'h555, 8'h80);
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55);
        key(a, code);
    endtask

    task automatic wait_op(input string tag, input logic [14:0] a, input int n,
                           input logic dq7, input logic [15:0] expd);
        logic tg;
        logic [15:0] r;
        tg = 1'b0;
        for (int k = 0; k < n; k++) begin
            rd(a, r);
            check(tag, r, {8'h00, dq7, tg, 6'h00});
            tg = ~tg;
        end
        rd(a, r);
        check(tag, r, expd);
    endtask

    task automatic sweep(input string tag);
        logic [15:0] r;
        for (int i = 0; i < WORDS; i++) begin
            rd(15'(i), r);
            check(tag, r, exp_mem[i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset rdata", rdata, 16'h0000);

        // R4 whole-array erase
        cmd_erase(15'h555, 8'h10);
        wait_op("R4 chip erase", 15'd0, CHIP_CYC, 1'b0, 16'hFFFF);
        for (int i = 0; i < WORDS; i++) exp_mem[i] = 16'hFFFF;
        sweep("R4 blank sweep");

        // R2 / R3 program every word
        for (int i = 0; i < WORDS; i++) begin
            logic [15:0] d;
            d = 16'(i * 16'h0301) ^ 16'hC65A;
            cmd_prog(15'(i), d);
            wait_op("R3 program status", 15'(i), PROG_CYC, ~d[7], d);
            exp_mem[i] = d;
        end
        sweep("R2 program sweep");

        // R5 sector erase at word 22
        cmd_erase(15'd22, 8'h50);
        wait_op("R5 sector erase", 15'd22, ERASE_CYC, 1'b0, 16'hFFFF);
        for (int i = 20; i < 24; i++) exp_mem[i] = 16'hFFFF;
        sweep("R5 sector sweep");

        // R6 block erase at word 40
        cmd_erase(15'd40, 8'h30);
        wait_op("R6 block erase", 15'd40, ERASE_CYC, 1'b0, 16'hFFFF);
        for (int i = 32; i < 48; i++) exp_mem[i] = 16'hFFFF;
        sweep("R6 block sweep");

        // R7 write protect
        wp_n = 1'b0;
        cmd_prog(15'd3, 16'h1111);
        rd(15'd3, q); check("R7 blocked program", q, exp_mem[3]);
        cmd_erase(15'd5, 8'h50);
        rd(15'd5, q); check("R7 blocked sector", q, exp_mem[5]);
        cmd_erase(15'd9, 8'h30);
        rd(15'd9, q); check("R7 blocked block", q, exp_mem[9]);
        cmd_prog(15'd50, 16'h0F0F);
        wait_op("R7 open program", 15'd50, PROG_CYC, 1'b1, 16'h0F0F);
        exp_mem[50] = 16'h0F0F;
        cmd_erase(15'h555, 8'h10);
        wait_op("R7 chip erase", 15'd30, CHIP_CYC, 1'b0, 16'hFFFF);
        for (int i = 16; i < WORDS; i++) exp_mem[i] = 16'hFFFF;
        sweep("R7 boot kept sweep");
        wp_n = 1'b1;

        // R8 writes during busy
        cmd_erase(15'h555, 8'h10);
        cmd_prog(15'd20, 16'h1234);
        repeat (CHIP_CYC + PROG_CYC) rd(15'd0, q);
        for (int i = 0; i < WORDS; i++) exp_mem[i] = 16'hFFFF;
        sweep("R8 ignored while busy");

        // prepare distinct words for R9/R10
        cmd_prog(15'd0, 16'hA5C3);
        wait_op("R3 program low", 15'd0, PROG_CYC, 1'b0, 16'hA5C3);
        exp_mem[0] = 16'hA5C3;
        cmd_prog(15'd1, 16'h7E01);
        wait_op("R3 program one", 15'd1, PROG_CYC, 1'b1, 16'h7E01);
        exp_mem[1] = 16'h7E01;

        // R9 identification
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55); key(15'h555, 8'h90);
        rd(15'd0, q); check("R9 maker", q, 16'h00BF);
        rd(15'd1, q); check("R9 part", q, 16'h235D);
        rd(15'd2, q); check("R9 other", q, 16'h0000);
        // R10 single-write exit
        wr(15'h0123, 16'h33F0);
        rd(15'd0, q); check("R10 single exit", q, exp_mem[0]);
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55); key(15'h555, 8'h90);
        rd(15'd1, q); check("R9 reentry", q, 16'h235D);
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55); key(15'h555, 8'hF0);
        rd(15'd1, q); check("R10 three-write exit", q, exp_mem[1]);

        // R11 broken sequences
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55); key(15'h555, 8'h33);
        key(15'h555, 8'hA0); wr(15'd7, 16'h0000);
        rd(15'd7, q); check("R11 broken program", q, exp_mem[7]);
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55); key(15'h555, 8'h80);
        key(15'h555, 8'hAA); key(15'h2AA, 8'h99); key(15'h555, 8'h10);
        rd(15'd0, q); check("R11 broken erase", q, exp_mem[0]);

        // R1 abort by reset
        cmd_prog(15'd12, 16'h0000);
        rd(15'd12, q); rd(15'd12, q);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 rdata after abort", rdata, 16'h0000);
        rd(15'd12, q); check("R1 aborted program", q, exp_mem[12]);
        key(15'h555, 8'hAA); key(15'h2AA, 8'h55); key(15'h555, 8'h90);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(15'd0, q); check("R1 reset leaves id mode", q, exp_mem[0]);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule